// File: doc/BRIEF.md
# Port pin-change interrupt controller

This block watches an 8-bit input port and raises a single interrupt request when a chosen edge appears on any pin that software has enabled. Every pin is brought into the clock domain through a two-stage synchronizer. It then passes through its own edge detector. A per-pin polarity bit decides whether that pin reacts to rising or falling transitions. A detected edge sets a sticky pending bit for that pin. The pending bit is set whether or not the pin is enabled. The request output is the registered OR of all pending bits that are also enabled.

Software reaches three byte-wide registers over a plain select/write register bus. The enable mask is at offset 0x266 and the pending flags are at 0x267. The polarity selects are at offset 0x268. Reads are combinational while the bus is selected. Pending bits are cleared only by writing ones to them. The bus has no stream traffic and no back-pressure: every access completes in the cycle it is presented.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the enable, pending and polarity registers read 0x00 and `irq_o` is low.
- R2: With a pin's polarity bit at 1, a low-to-high transition on that pin sets its pending bit. The bit is readable by the fourth rising clock edge after the pin changes. A high-to-low transition on that pin sets nothing.
- R3: With a pin's polarity bit at 0, a high-to-low transition on that pin sets its pending bit, and a low-to-high transition sets nothing.
- R4: A pending bit is set even when its enable bit is 0. While no set pending bit has its enable bit set, `irq_o` stays low.
- R5: Writing the pending register at 0x267 clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: `irq_o` is high in a cycle exactly when, in the previous cycle, some bit i had both pending[i] and enable[i] set. It falls one cycle after the last such pair is cleared or disabled.
- R7: When an active edge and a clearing write hit the same pending bit on the same clock edge, the bit stays set.
- R8: Changing a polarity bit while its pin holds a steady level sets no pending bit.
- R9: Register bit i corresponds to pin i. Enable is read/write at 0x266, pending at 0x267 and polarity at 0x268. Any other address reads 0x00.
- R10: A pending bit stays set after its pin returns to the idle level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_sel` is high |
| irq_o | output | 1 | Registered interrupt request level |

## Verification
A pending bit that is set wrongly, or not cleared when it should be, shows up in the pending register read-back. If that pin is enabled, it also shows on `irq_o` one cycle later. An edge that the detector loses shows as a pending bit still reading zero four clock edges after the pin moved. A false edge caused by a polarity write shows the same way, as a bit that should read zero but reads one. A corrupted enable or polarity register shows directly when it is read back. A wrong enable value also shows as a request level that disagrees, one cycle later, with the pending and enable values read back.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int PORT_W = 8;
  localparam int BUS_AW = 12;
  localparam logic [BUS_AW-1:0] OFS_ENABLE  = 12'h266;
  localparam logic [BUS_AW-1:0] OFS_PENDING = 12'h267;
  localparam logic [BUS_AW-1:0] OFS_POLSEL  = 12'h268;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_ENABLE,
    REG_PENDING,
    REG_POLSEL
  } reg_sel_e;
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pei_edge.sv
module pei_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  // Transition found on raw levels first; polarity only picks which one counts.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic went_up, went_down;
    assign went_up   =  lvl[b] & ~prev_q[b];
    assign went_down = ~lvl[b] &  prev_q[b];
    assign evt[b]    = rise_sel[b] ? went_up : went_down;
  end
endmodule

// File: rtl/pei_regs.sv
module pei_regs
  import pei_pkg::*;
#(
  parameter int                W        = 8,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFF_EN   = 12'h266,
  parameter logic [ADDR_W-1:0] OFF_FLAG = 12'h267,
  parameter logic [ADDR_W-1:0] OFF_POL  = 12'h268
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      evt,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      flag_q,
  output logic [W-1:0]      pol_q,
  output logic              irq_q
);
  reg_sel_e       sel;
  logic [W-1:0]   clr_mask;
  logic [W-1:0]   flag_d;

  always_comb begin
    sel = REG_NONE;
    if (bus_sel) begin
      if      (bus_addr == OFF_EN)   sel = REG_ENABLE;
      else if (bus_addr == OFF_FLAG) sel = REG_PENDING;
      else if (bus_addr == OFF_POL)  sel = REG_POLSEL;
    end
  end

  assign clr_mask = (bus_wr && sel == REG_PENDING) ? bus_wdata : '0;
  // New edges are OR-ed after the clear, so a colliding event survives.
  assign flag_d   = (flag_q & ~clr_mask) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (bus_wr && sel == REG_ENABLE) en_q  <= bus_wdata;
      if (bus_wr && sel == REG_POLSEL) pol_q <= bus_wdata;
      flag_q <= flag_d;
      irq_q  <= |(flag_q & en_q);
    end
  end

  always_comb begin
    case (sel)
      REG_ENABLE:  bus_rdata = en_q;
      REG_PENDING: bus_rdata = flag_q;
      REG_POLSEL:  bus_rdata = pol_q;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int                NPINS    = pei_pkg::PORT_W,
  parameter int                ADDR_W   = pei_pkg::BUS_AW,
  parameter logic [ADDR_W-1:0] OFF_EN   = pei_pkg::OFS_ENABLE,
  parameter logic [ADDR_W-1:0] OFF_FLAG = pei_pkg::OFS_PENDING,
  parameter logic [ADDR_W-1:0] OFF_POL  = pei_pkg::OFS_POLSEL,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] evt_vec;
  logic [NPINS-1:0] en_vec;
  logic [NPINS-1:0] flag_vec;
  logic [NPINS-1:0] pol_vec;

  pei_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (pin_i),
    .q   (lvl_sync)
  );

  pei_edge #(.W(NPINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl_sync),
    .rise_sel (pol_vec),
    .evt      (evt_vec)
  );

  pei_regs #(
    .W(NPINS), .ADDR_W(ADDR_W),
    .OFF_EN(OFF_EN), .OFF_FLAG(OFF_FLAG), .OFF_POL(OFF_POL)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt       (evt_vec),
    .en_q      (en_vec),
    .flag_q    (flag_vec),
    .pol_q     (pol_vec),
    .irq_q     (irq_o)
  );
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
  parameter int                W        = 8,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFF_FLAG = 12'h267
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      evt_vec,
  input logic [W-1:0]      en_vec,
  input logic [W-1:0]      flag_vec,
  input logic              irq_o
);
  p_edge_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((flag_vec & $past(evt_vec)) == $past(evt_vec)));

  p_masked_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_vec & en_vec) == '0) |=> !irq_o);

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFF_FLAG)
      |=> ((flag_vec & $past(bus_wdata) & ~$past(evt_vec)) == '0));

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_vec & en_vec) != '0) |=> irq_o);

  p_no_spurious_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_vec & ~$past(flag_vec) & ~$past(evt_vec)) == '0));
endmodule

bind pin_edge_irq pin_edge_irq_chk #(
  .W(NPINS), .ADDR_W(ADDR_W), .OFF_FLAG(OFF_FLAG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_vec   (evt_vec),
  .en_vec    (en_vec),
  .flag_vec  (flag_vec),
  .irq_o     (irq_o)
);

// File: tb/tb_pin_edge_irq.sv
`timescale 1ns/1ps
module tb_pin_edge_irq;
  localparam logic [11:0] A_EN   = 12'h266;
  localparam logic [11:0] A_FLAG = 12'h267;
  localparam logic [11:0] A_POL  = 12'h268;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          checks = 0;
  int          fails  = 0;

  always #2.5 clk = ~clk;

  pin_edge_irq dut (
    .clk (clk), .rst_n (rst_n), .pin_i (pins),
    .bus_sel (sel), .bus_wr (wr), .bus_addr (addr),
    .bus_wdata (wdata), .bus_rdata (rdata), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(A_EN, v);   chk("R1 enable reset", v, 8'h00);
    bus_read(A_FLAG, v); chk("R1 pending reset", v, 8'h00);
    bus_read(A_POL, v);  chk("R1 polarity reset", v, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    bus_write(A_EN, 8'hA5);  bus_read(A_EN, v);  chk("R9 enable readback", v, 8'hA5);
    bus_write(A_POL, 8'h5A); bus_read(A_POL, v); chk("R9 polarity readback", v, 8'h5A);
    bus_read(12'h265, v); chk("R9 unmapped low", v, 8'h00);
    bus_read(12'h269, v); chk("R9 unmapped high", v, 8'h00);
    bus_write(A_EN, 8'h00);
    bus_write(A_POL, 8'h00);
  endtask

  task automatic t_rising;
    logic [7:0] v;
    bus_write(A_POL, 8'h01);
    set_pins(8'h01);
    bus_read(A_FLAG, v); chk("R2 rising sets pin0", v, 8'h01);
    chk("R4 masked flag keeps irq low", {7'd0, irq}, 8'h00);
    set_pins(8'h00);
    bus_read(A_FLAG, v); chk("R10 sticky after falling", v, 8'h01);
  endtask

  task automatic t_falling;
    logic [7:0] v;
    set_pins(8'h02);
    bus_read(A_FLAG, v); chk("R3 rising ignored on pin1", v, 8'h01);
    set_pins(8'h00);
    bus_read(A_FLAG, v); chk("R3 falling sets pin1", v, 8'h03);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    bus_write(A_FLAG, 8'h00);
    bus_read(A_FLAG, v); chk("R5 write zero no effect", v, 8'h03);
    bus_write(A_FLAG, 8'h01);
    bus_read(A_FLAG, v); chk("R5 write one clears", v, 8'h02);
  endtask

  task automatic t_irq;
    bus_write(A_EN, 8'h02);
    @(posedge clk); #1;
    chk("R6 irq after enable", {7'd0, irq}, 8'h01);
    bus_write(A_FLAG, 8'h02);
    @(posedge clk); #1;
    chk("R6 irq after clear", {7'd0, irq}, 8'h00);
    bus_write(A_EN, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    bus_write(A_POL, 8'h04);
    set_pins(8'h04);
    bus_read(A_FLAG, v); chk("R2 rising sets pin2", v, 8'h04);
    set_pins(8'h00);
    @(negedge clk);
    pins = 8'h04;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = A_FLAG; wdata = 8'h04;
    @(posedge clk);
    #1 sel = 1'b0; wr = 1'b0;
    bus_read(A_FLAG, v); chk("R7 set wins over clear", v, 8'h04);
  endtask

  task automatic t_polchange;
    logic [7:0] v;
    bus_write(A_FLAG, 8'hFF);
    bus_write(A_POL, 8'hFF);
    repeat (4) @(posedge clk);
    bus_read(A_FLAG, v); chk("R8 polarity to rising, steady pins", v, 8'h00);
    bus_write(A_POL, 8'h00);
    repeat (4) @(posedge clk);
    bus_read(A_FLAG, v); chk("R8 polarity to falling, steady pins", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_rising();
    t_falling();
    t_w1c();
    t_irq();
    t_collide();
    t_polchange();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule